// File: doc/BRIEF.md
# Reset Source Combiner and Start-Up Timer

This block merges the reset requests of a small controller into one internal reset line and keeps that line asserted for a programmable start-up delay after the last request goes away. Four requests are accepted, all as digital levels or strobes: a power-on level, a brown-out level, an active-low external reset pin and a one-cycle watchdog expiry strobe. While any request is present the internal reset is high at once, through combinational logic alone. After the last request is released, a two-phase delay runs: first a number of watchdog-oscillator ticks, then a number of system clocks. A 3-bit code picks the pair of counts from an eight-entry table.

The watchdog oscillator reaches the block as a one-cycle tick strobe in the system clock domain. Every count in the table is a parameter, so an integration can scale the delays and a bench can shorten them.

Beside the timer, a 4-bit cause register records which request types have occurred. A power-on request loads it with only the power-on bit set. Every other request type sets its own bit. Software clears bits by writing zeros to them through a small write port.

Top module: `rst_startup_ctrl`

## Requirements
- R1: In any cycle where `por_req`, `bod_req` or `wdt_expire` is 1, or `ext_rst_n` is 0, `core_rst` is 1 in that same cycle, with no clock edge needed.
- R2: Call edge 0 the last rising clock edge at which a request is sampled. Count the later edges 1, 2, and so on. Let e be the edge at which the T-th `wdt_tick` strobe is sampled, with e = 0 when T = 0. `core_rst` stays 1 until edge e+C, then drops to 0 and stays 0 until a new request arrives. T and C are the tick count and clock count selected by R3.
- R3: The `sel` code chooses the pair (T, C) as follows: 0 gives (TICKS_SHORT, CLKS_SHORT), 1 gives (0, CLKS_SHORT), 2 gives (TICKS_LONG, CLKS_LONG), 3 gives (TICKS_SHORT, CLKS_LONG), 4 gives (0, CLKS_LONG), 5 gives (TICKS_LONG, CLKS_MID), 6 gives (TICKS_SHORT, CLKS_MID) and 7 gives (0, CLKS_MID).
- R4: A request that arrives while the delay is still running, in either the tick phase or the clock phase, clears both counters. The full delay then restarts from the new release.
- R5: The code is captured at edge 0. Changes on `sel` after the release do not alter the delay that is already running.
- R6: The cause bits are: bit 3 watchdog, bit 2 brown-out, bit 1 external pin, bit 0 power-on. At every edge where `por_req` is 1, the register is loaded with 4'b0001.
- R7: Without a power-on request, each of `wdt_expire`, `bod_req` and `ext_rst_n` = 0 sets its own bit at the next edge and leaves the other bits unchanged. Causes that arrive together set all of their bits.
- R8: With `flag_wr_en` = 1, each bit written as 0 is cleared and each bit written as 1 is left unchanged. A cause that sets a bit in the same cycle wins over a write that clears it. Without a write or a cause, the register holds its value.
- R9: The power-on bit is cleared only by a software write of 0 to bit 0. Watchdog, brown-out and external requests leave it unchanged.
- R10: A `wdt_expire` strobe lasting one cycle raises `core_rst` for that cycle. The delay of R2 then starts from the edge that sampled the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, active high |
| bod_req | input | 1 | Brown-out request, active high |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_expire | input | 1 | Watchdog expiry strobe, one cycle |
| wdt_tick | input | 1 | Watchdog oscillator tick strobe, in the clk domain |
| sel | input | 3 | Start-up delay code |
| flag_wr_en | input | 1 | Write strobe for the cause register |
| flag_wr_data | input | 4 | Write data; a 0 clears the matching bit |
| core_rst | output | 1 | Internal reset, active high |
| cause_flags | output | 4 | Cause register |

## Verification
The hardest cases to reach are requests that arrive again partway through a delay. Such a request must land in a chosen phase, either while ticks are still being counted or after the tick phase has ended. The stimulus places the tick strobes at a fixed period after each release, so the bench knows the cycle in which each phase ends. It then re-asserts brown-out in a chosen cycle. A second hard case is a software clear that lands in the same cycle as a brown-out set. The bench drives both on one falling edge and reads the register on the next.

// File: rtl/rst_startup_pkg.sv
package rst_startup_pkg;

    localparam int CAUSE_W   = 4;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_EXT = 1;
    localparam int CAUSE_BOD = 2;
    localparam int CAUSE_WDT = 3;

    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [2:0]         sel_t;

    // value loaded by a power-on request: only the power-on bit set
    localparam cause_t CAUSE_AFTER_POR = cause_t'(1) << CAUSE_POR;

    typedef enum logic [1:0] {
        PH_TICK = 2'd0,
        PH_CLK  = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

endpackage

// File: rtl/rst_startup_table.sv
module rst_startup_table
    import rst_startup_pkg::*;
#(
    parameter int TICKS_SHORT = 4096,
    parameter int TICKS_LONG  = 65536,
    parameter int CLKS_SHORT  = 6,
    parameter int CLKS_MID    = 1024,
    parameter int CLKS_LONG   = 16384,
    parameter int TICK_W      = 17,
    parameter int CLK_W       = 15
) (
    input  sel_t              sel,
    output logic [TICK_W-1:0] tick_tgt,
    output logic [CLK_W-1:0]  clk_tgt
);

    localparam logic [TICK_W-1:0] T_NONE  = '0;
    localparam logic [TICK_W-1:0] T_SHORT = TICK_W'(TICKS_SHORT);
    localparam logic [TICK_W-1:0] T_LONG  = TICK_W'(TICKS_LONG);
    localparam logic [CLK_W-1:0]  C_SHORT = CLK_W'(CLKS_SHORT);
    localparam logic [CLK_W-1:0]  C_MID   = CLK_W'(CLKS_MID);
    localparam logic [CLK_W-1:0]  C_LONG  = CLK_W'(CLKS_LONG);

    always_comb begin
        unique case (sel)
            3'd0:    begin tick_tgt = T_SHORT; clk_tgt = C_SHORT; end
            3'd1:    begin tick_tgt = T_NONE;  clk_tgt = C_SHORT; end
            3'd2:    begin tick_tgt = T_LONG;  clk_tgt = C_LONG;  end
            3'd3:    begin tick_tgt = T_SHORT; clk_tgt = C_LONG;  end
            3'd4:    begin tick_tgt = T_NONE;  clk_tgt = C_LONG;  end
            3'd5:    begin tick_tgt = T_LONG;  clk_tgt = C_MID;   end
            3'd6:    begin tick_tgt = T_SHORT; clk_tgt = C_MID;   end
            default: begin tick_tgt = T_NONE;  clk_tgt = C_MID;   end
        endcase
    end

endmodule

// File: rtl/rst_startup_seq.sv
module rst_startup_seq
    import rst_startup_pkg::*;
#(
    parameter int TICK_W = 17,
    parameter int CLK_W  = 15
) (
    input  logic              clk,
    input  logic              any_req,
    input  logic              wdt_tick,
    input  sel_t              sel_in,
    input  logic [TICK_W-1:0] tick_tgt,
    input  logic [CLK_W-1:0]  clk_tgt,
    output sel_t              sel_held,
    output logic              busy
);

    typedef struct packed {
        phase_e            phase;
        logic [TICK_W-1:0] tick_cnt;
        logic [CLK_W-1:0]  clk_cnt;
        sel_t              sel;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [TICK_W-1:0] tick_inc;
    logic [CLK_W-1:0]  clk_inc;

    assign tick_inc = seq_q.tick_cnt + TICK_W'(1);
    assign clk_inc  = seq_q.clk_cnt  + CLK_W'(1);

    always_comb begin
        seq_d = seq_q;
        if (any_req) begin
            // any request, power-on included, re-arms both counters
            seq_d.phase    = PH_TICK;
            seq_d.tick_cnt = '0;
            seq_d.clk_cnt  = '0;
            seq_d.sel      = sel_in;
        end else begin
            unique case (seq_q.phase)
                PH_TICK: begin
                    if (seq_q.tick_cnt == tick_tgt) begin
                        // empty tick phase: this edge already counts as a clock
                        seq_d.phase   = (clk_inc == clk_tgt) ? PH_RUN : PH_CLK;
                        seq_d.clk_cnt = (clk_inc == clk_tgt) ? '0 : clk_inc;
                    end else if (wdt_tick) begin
                        if (tick_inc == tick_tgt) begin
                            seq_d.phase   = PH_CLK;
                            seq_d.clk_cnt = '0;
                        end else begin
                            seq_d.tick_cnt = tick_inc;
                        end
                    end
                end
                PH_CLK: begin
                    if (clk_inc == clk_tgt) begin
                        seq_d.phase   = PH_RUN;
                        seq_d.clk_cnt = '0;
                    end else begin
                        seq_d.clk_cnt = clk_inc;
                    end
                end
                default: seq_d = seq_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign sel_held = seq_q.sel;
    assign busy     = (seq_q.phase != PH_RUN);

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_startup_pkg::*;
(
    input  logic   clk,
    input  logic   por_req,
    input  logic   bod_req,
    input  logic   ext_act,
    input  logic   wdt_expire,
    input  logic   wr_en,
    input  cause_t wr_data,
    output cause_t flags
);

    typedef struct packed {
        cause_t flags;
    } cause_st_t;

    cause_st_t cs_d, cs_q;
    cause_t    set_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[CAUSE_WDT] = wdt_expire;
        set_vec[CAUSE_BOD] = bod_req;
        set_vec[CAUSE_EXT] = ext_act;
        for (int b = 0; b < CAUSE_W; b++) begin
            cs_d.flags[b] = (cs_q.flags[b] & (wr_data[b] | ~wr_en)) | set_vec[b];
        end
    end

    always_ff @(posedge clk) begin
        if (por_req) begin
            cs_q.flags <= CAUSE_AFTER_POR;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign flags = cs_q.flags;

endmodule

// File: rtl/rst_startup_ctrl.sv
module rst_startup_ctrl
    import rst_startup_pkg::*;
#(
    parameter int TICKS_SHORT = 4096,
    parameter int TICKS_LONG  = 65536,
    parameter int CLKS_SHORT  = 6,
    parameter int CLKS_MID    = 1024,
    parameter int CLKS_LONG   = 16384
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       bod_req,
    input  logic       ext_rst_n,
    input  logic       wdt_expire,
    input  logic       wdt_tick,
    input  logic [2:0] sel,
    input  logic       flag_wr_en,
    input  logic [3:0] flag_wr_data,
    output logic       core_rst,
    output logic [3:0] cause_flags
);

    localparam int TICK_MAX = (TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT;
    localparam int CLK_MAX  = (CLKS_LONG > CLKS_MID) ?
                              ((CLKS_LONG > CLKS_SHORT) ? CLKS_LONG : CLKS_SHORT) :
                              ((CLKS_MID > CLKS_SHORT) ? CLKS_MID : CLKS_SHORT);
    localparam int TICK_W   = $clog2(TICK_MAX + 1);
    localparam int CLK_W    = $clog2(CLK_MAX + 1);

    logic              any_req;
    logic              busy;
    sel_t              sel_held;
    logic [TICK_W-1:0] tick_tgt;
    logic [CLK_W-1:0]  clk_tgt;

    assign any_req  = por_req | bod_req | ~ext_rst_n | wdt_expire;
    assign core_rst = any_req | busy;

    rst_startup_table #(
        .TICKS_SHORT (TICKS_SHORT),
        .TICKS_LONG  (TICKS_LONG),
        .CLKS_SHORT  (CLKS_SHORT),
        .CLKS_MID    (CLKS_MID),
        .CLKS_LONG   (CLKS_LONG),
        .TICK_W      (TICK_W),
        .CLK_W       (CLK_W)
    ) u_table (
        .sel      (sel_held),
        .tick_tgt (tick_tgt),
        .clk_tgt  (clk_tgt)
    );

    rst_startup_seq #(
        .TICK_W (TICK_W),
        .CLK_W  (CLK_W)
    ) u_seq (
        .clk      (clk),
        .any_req  (any_req),
        .wdt_tick (wdt_tick),
        .sel_in   (sel),
        .tick_tgt (tick_tgt),
        .clk_tgt  (clk_tgt),
        .sel_held (sel_held),
        .busy     (busy)
    );

    rst_cause_reg u_cause (
        .clk        (clk),
        .por_req    (por_req),
        .bod_req    (bod_req),
        .ext_act    (~ext_rst_n),
        .wdt_expire (wdt_expire),
        .wr_en      (flag_wr_en),
        .wr_data    (flag_wr_data),
        .flags      (cause_flags)
    );

endmodule

// File: rtl/rst_startup_ctrl_chk.sv
module rst_startup_ctrl_chk (
    input logic       clk,
    input logic       por_req,
    input logic       bod_req,
    input logic       ext_rst_n,
    input logic       wdt_expire,
    input logic       flag_wr_en,
    input logic [3:0] flag_wr_data,
    input logic       core_rst,
    input logic [3:0] cause_flags
);

    logic other_req;
    assign other_req = bod_req | ~ext_rst_n | wdt_expire;

    // R1
    req_forces_rst_chk: assert property (@(posedge clk) disable iff (por_req)
        other_req |-> core_rst);

    // R2
    no_spurious_rst_chk: assert property (@(posedge clk) disable iff (por_req)
        !core_rst |=> (!core_rst || other_req));

    // R10
    wdt_starts_timeout_chk: assert property (@(posedge clk) disable iff (por_req)
        wdt_expire |=> core_rst);

    // R7
    bod_flag_chk: assert property (@(posedge clk) disable iff (por_req)
        bod_req |=> cause_flags[2]);

    // R7
    ext_flag_chk: assert property (@(posedge clk) disable iff (por_req)
        !ext_rst_n |=> cause_flags[1]);

    // R7
    wdt_flag_chk: assert property (@(posedge clk) disable iff (por_req)
        wdt_expire |=> cause_flags[3]);

    // R9
    porf_sw_clear_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(cause_flags[0]) |-> $past(flag_wr_en && !flag_wr_data[0]));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (por_req)
        (!flag_wr_en && !other_req) |=> $stable(cause_flags));

endmodule

bind rst_startup_ctrl rst_startup_ctrl_chk u_chk (
    .clk          (clk),
    .por_req      (por_req),
    .bod_req      (bod_req),
    .ext_rst_n    (ext_rst_n),
    .wdt_expire   (wdt_expire),
    .flag_wr_en   (flag_wr_en),
    .flag_wr_data (flag_wr_data),
    .core_rst     (core_rst),
    .cause_flags  (cause_flags)
);

// File: tb/rst_startup_ctrl_tb.sv
module rst_startup_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int WD_CYCLES  = 20000;
    localparam int TS = 3;
    localparam int TL = 5;
    localparam int CS = 2;
    localparam int CM = 4;
    localparam int CL = 7;

    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic       bod_req = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdt_expire = 1'b0;
    logic       wdt_tick = 1'b0;
    logic [2:0] sel = 3'd2;
    logic       flag_wr_en = 1'b0;
    logic [3:0] flag_wr_data = 4'h0;
    logic       core_rst;
    logic [3:0] cause_flags;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int    len;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_startup_ctrl #(
        .TICKS_SHORT (TS),
        .TICKS_LONG  (TL),
        .CLKS_SHORT  (CS),
        .CLKS_MID    (CM),
        .CLKS_LONG   (CL)
    ) u_dut (
        .clk          (clk),
        .por_req      (por_req),
        .bod_req      (bod_req),
        .ext_rst_n    (ext_rst_n),
        .wdt_expire   (wdt_expire),
        .wdt_tick     (wdt_tick),
        .sel          (sel),
        .flag_wr_en   (flag_wr_en),
        .flag_wr_data (flag_wr_data),
        .core_rst     (core_rst),
        .cause_flags  (cause_flags)
    );

    function automatic int exp_ticks(input logic [2:0] s);
        case (s)
            3'd0, 3'd3, 3'd6: return TS;
            3'd2, 3'd5:       return TL;
            default:          return 0;
        endcase
    endfunction

    function automatic int exp_clks(input logic [2:0] s);
        case (s)
            3'd0, 3'd1:       return CS;
            3'd2, 3'd3, 3'd4: return CL;
            default:          return CM;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] mask);
        por_req    = mask[0];
        bod_req    = mask[1];
        ext_rst_n  = !mask[2];
        wdt_expire = mask[3];
    endtask

    task automatic push_exp(input int len, input string tag);
        exp_item_t it;
        it.len = len;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // driver: request for `hold` cycles, release, tick strobe every p cycles
    task automatic run_case(input logic [3:0] mask, input logic [2:0] s,
                            input logic [2:0] s_after, input int p,
                            input int hold, input string tag);
        int len;
        @(negedge clk);
        apply(mask);
        sel = s;
        wdt_tick = 1'b0;
        for (int h = 0; h < hold; h++) begin
            if (h > 0) wdt_expire = 1'b0;
            #(QTR);
            check(core_rst == 1'b1, "R1 core_rst during request", int'(core_rst), 1);
            @(negedge clk);
        end
        apply(4'b0000);
        sel = s_after;
        len = p * exp_ticks(s) + exp_clks(s);
        push_exp(len, tag);
        for (int i = 1; i <= len + 3; i++) begin
            wdt_tick = ((i % p) == 0);
            @(negedge clk);
        end
        wdt_tick = 1'b0;
    endtask

    task automatic write_flags(input logic [3:0] data);
        @(negedge clk);
        flag_wr_en   = 1'b1;
        flag_wr_data = data;
        @(negedge clk);
        flag_wr_en   = 1'b0;
        #(QTR);
    endtask

    // monitor: measures reset length after each release and scores it
    initial begin
        int        cnt;
        exp_item_t it;
        cnt = 0;
        forever begin
            @(negedge clk);
            #(QTR);
            if (por_req || bod_req || !ext_rst_n || wdt_expire) begin
                cnt = 0;
            end else if (core_rst) begin
                cnt++;
            end else if (cnt > 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected reset release", cnt, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(cnt == it.len, it.tag, cnt, it.len);
                end
                cnt = 0;
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state under power-on
        @(negedge clk);
        #(QTR);
        check(core_rst == 1'b1, "R1 core_rst under power-on", int'(core_rst), 1);
        check(cause_flags == 4'b0001, "R6 flags under power-on", int'(cause_flags), 1);

        // power-on release, code 2, tick every cycle
        run_case(4'b0001, 3'd2, 3'd2, 1, 3, "R2 power-on code 2");
        check(cause_flags == 4'b0001, "R6 flags after power-on", int'(cause_flags), 1);

        // brown-out, code 0, tick every second cycle
        run_case(4'b0010, 3'd0, 3'd0, 2, 2, "R2 brown-out code 0");
        check(cause_flags == 4'b0101, "R9 power-on bit kept by brown-out",
              int'(cause_flags), 5);

        // software clears power-on bit only
        write_flags(4'b1110);
        check(cause_flags == 4'b0100, "R9 power-on bit cleared by write",
              int'(cause_flags), 4);
        write_flags(4'b1111);
        check(cause_flags == 4'b0100, "R8 write of ones keeps flags",
              int'(cause_flags), 4);

        // external and watchdog together
        run_case(4'b1100, 3'd7, 3'd7, 3, 2, "R2 external+watchdog code 7");
        check(cause_flags == 4'b1110, "R7 simultaneous causes", int'(cause_flags), 14);

        // clear all while brown-out sets in the same cycle
        @(negedge clk);
        bod_req      = 1'b1;
        sel          = 3'd1;
        flag_wr_en   = 1'b1;
        flag_wr_data = 4'b0000;
        @(negedge clk);
        flag_wr_en   = 1'b0;
        #(QTR);
        check(cause_flags == 4'b0100, "R8 set wins over clear", int'(cause_flags), 4);
        @(negedge clk);
        bod_req = 1'b0;
        push_exp(exp_clks(3'd1), "R3 code 1 no ticks");
        repeat (6) @(negedge clk);

        // watchdog strobe alone, one cycle
        run_case(4'b1000, 3'd6, 3'd6, 1, 1, "R10 watchdog strobe code 6");
        check(cause_flags == 4'b1100, "R9 watchdog keeps power-on bit clear",
              int'(cause_flags), 12);

        // code change after release has no effect
        run_case(4'b0010, 3'd5, 3'd1, 1, 2, "R5 code held after release");

        // R4: restart during tick phase, code 3, tick every 2 cycles
        @(negedge clk);
        apply(4'b0010);
        sel = 3'd3;
        repeat (2) @(negedge clk);
        apply(4'b0000);
        for (int i = 1; i <= 4; i++) begin
            wdt_tick = ((i % 2) == 0);
            @(negedge clk);
        end
        wdt_tick = 1'b0;
        apply(4'b0010);
        repeat (2) @(negedge clk);
        apply(4'b0000);
        push_exp(2 * TS + CL, "R4 restart in tick phase");
        for (int i = 1; i <= 2 * TS + CL + 3; i++) begin
            wdt_tick = ((i % 2) == 0);
            @(negedge clk);
        end
        wdt_tick = 1'b0;

        // R4: restart during clock phase, code 4
        apply(4'b0010);
        sel = 3'd4;
        repeat (2) @(negedge clk);
        apply(4'b0000);
        repeat (4) @(negedge clk);
        apply(4'b0010);
        @(negedge clk);
        apply(4'b0000);
        push_exp(CL, "R4 restart in clock phase");
        repeat (CL + 3) @(negedge clk);

        // every code through the external pin
        for (int s = 0; s < 8; s++) begin
            run_case(4'b0100, 3'(s), 3'(s), 2, 2, "R3 code table");
        end

        // power-on again reloads flags
        write_flags(4'b1111);
        run_case(4'b0001, 3'd4, 3'd4, 1, 2, "R2 power-on code 4");
        check(cause_flags == 4'b0001, "R6 power-on reloads flags", int'(cause_flags), 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all releases observed", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule